// File: doc/BRIEF.md
# Indirect-Indexed Load Address Sequencer

This block steps an 8-bit processor through one load instruction whose operand address is formed indirectly. A one-byte operand names a location in page zero. Two bytes are read from there to form a 16-bit pointer, and an 8-bit index is added to that pointer to give the address of the byte to load. The sequencer drives a registered 16-bit address bus and a read strobe, and it samples read data from a memory with combinational read. It advances its own program counter past the opcode and the operand, and it reports the loaded byte on an accumulator output together with a one-cycle done pulse.

The cycle count follows the carry out of the index addition. If the low pointer byte plus the index stays inside the page, the data read comes in the cycle right after the pointer-high read, so the load takes five bus cycles. If the addition carries, the sequencer first issues a read whose result is thrown away, at the new low byte joined to the old high byte. It corrects the high byte during that cycle and then reads the real address, which makes six bus cycles. The start request is honoured when the block is idle and also in the final data cycle, so loads can follow each other with no gap.

Top module: `izy_load_seq`

## Requirements
- R1: After a synchronous reset the read strobe and done are low, the address bus and the accumulator are 0, and the program counter equals the RESET_PC parameter (default 16'h0200).
- R2: A start request while idle makes the next cycle an opcode read at PC and the cycle after it an operand read at PC+1. When the load ends, PC equals its start value plus 2.
- R3: The pointer low byte is read at {8'h00, operand} and the pointer high byte at {8'h00, operand+1}. The increment wraps inside page zero, so operand 8'hFF reads the high byte at 16'h0000.
- R4: When low byte plus index is below 256, the cycle after the pointer-high read reads {high, low+index}. The load then uses exactly 5 strobed cycles.
- R5: When low byte plus index carries, the cycle after the pointer-high read reads {high, (low+index) mod 256} and discards the data. The next cycle reads {high+1, (low+index) mod 256}, for exactly 6 strobed cycles. For example, pointer bytes 8'h80/8'h10 with index 8'hF1 give 16'h1071 and then 16'h1171.
- R6: The high-byte correction wraps, so a pointer high byte of 8'hFF with a carry gives a final address in page 8'h00.
- R7: Done is high for exactly one cycle, the cycle after the final read, and the accumulator then holds the byte read in that final cycle.
- R8: A start request during any cycle of a load other than the final data cycle is ignored and leaves the address sequence unchanged. A start request in the final data cycle makes the next cycle an opcode read at the new PC, in the same cycle as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request for one load |
| idx_y | input | 8 | Index added to the pointer, sampled in the pointer-high cycle |
| rd_data | input | 8 | Read data for the address currently on the bus |
| bus_addr | output | 16 | Registered address bus |
| bus_rd | output | 1 | Registered read strobe |
| acc_out | output | 8 | Loaded byte |
| done | output | 1 | One-cycle pulse when the load finishes |
| pc_out | output | 16 | Program counter |

## Verification
The completion of one load and the opcode fetch of the next can fall in the same cycle. Done rises together with a strobed read at the new PC when the start request is held high during the final data read. The bench provokes this by raising the start request exactly in the final strobed cycle of a page-crossing load. In the following cycle it checks that done, the strobe and the new PC address are all present together. It then traces the second load from that cycle and compares its addresses and its loaded byte against the values built from its vector.

// File: rtl/izy_pkg.sv
package izy_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_OPC  = 3'd1,
    S_OPR  = 3'd2,
    S_PLO  = 3'd3,
    S_PHI  = 3'd4,
    S_FIX  = 3'd5,
    S_DATA = 3'd6
  } seq_st_e;
endpackage

// File: rtl/izy_pc_ctr.sv
module izy_pc_ctr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_PC = 16'h0200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_next
);
  assign pc_next = pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else if (inc) pc <= pc_next;
  end
endmodule

// File: rtl/izy_idx_add.sv
module izy_idx_add #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] base_lo,
  input  logic [DW-1:0] index,
  output logic [DW-1:0] sum_lo,
  output logic          carry
);
  logic [DW:0] full;
  assign full   = {1'b0, base_lo} + {1'b0, index};
  assign sum_lo = full[DW-1:0];
  assign carry  = full[DW];
endmodule

// File: rtl/izy_load_seq.sv
module izy_load_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] RESET_PC = 16'h0200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic [DW-1:0] acc_out,
  output logic          done,
  output logic [AW-1:0] pc_out
);
  import izy_pkg::*;

  localparam int HW = AW - DW;

  seq_st_e       state;
  logic [DW-1:0] zp_ptr;
  logic [DW-1:0] ptr_lo;
  logic [DW-1:0] eff_lo;
  logic [HW-1:0] eff_hi;
  logic [AW-1:0] pc_next;
  logic          pc_inc;
  logic [DW-1:0] sum_lo;
  logic          idx_carry;
  logic [DW-1:0] zp_next;

  assign pc_inc  = (state == S_OPC) || (state == S_OPR);
  assign zp_next = zp_ptr + 1'b1;

  izy_pc_ctr #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .inc     (pc_inc),
    .pc      (pc_out),
    .pc_next (pc_next)
  );

  izy_idx_add #(.DW(DW)) u_add (
    .base_lo (ptr_lo),
    .index   (idx_y),
    .sum_lo  (sum_lo),
    .carry   (idx_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      bus_addr <= '0;
      bus_rd   <= 1'b0;
      acc_out  <= '0;
      done     <= 1'b0;
      zp_ptr   <= '0;
      ptr_lo   <= '0;
      eff_lo   <= '0;
      eff_hi   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (go) begin
            bus_addr <= pc_out;
            bus_rd   <= 1'b1;
            state    <= S_OPC;
          end
        end
        S_OPC: begin
          bus_addr <= pc_next;
          state    <= S_OPR;
        end
        S_OPR: begin
          zp_ptr   <= rd_data;
          bus_addr <= {{HW{1'b0}}, rd_data};
          state    <= S_PLO;
        end
        S_PLO: begin
          ptr_lo   <= rd_data;
          bus_addr <= {{HW{1'b0}}, zp_next};
          state    <= S_PHI;
        end
        S_PHI: begin
          eff_lo   <= sum_lo;
          eff_hi   <= rd_data[HW-1:0];
          bus_addr <= {rd_data[HW-1:0], sum_lo};
          state    <= idx_carry ? S_FIX : S_DATA;
        end
        S_FIX: begin
          bus_addr <= {eff_hi + 1'b1, eff_lo};
          state    <= S_DATA;
        end
        S_DATA: begin
          acc_out <= rd_data;
          done    <= 1'b1;
          if (go) begin
            bus_addr <= pc_out;
            state    <= S_OPC;
          end else begin
            bus_rd <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: begin
          bus_rd <= 1'b0;
          state  <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/izy_load_seq_chk.sv
module izy_load_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            go,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_rd,
  input logic            done,
  input logic [AW-1:0]   pc_out,
  input izy_pkg::seq_st_e st
);
  import izy_pkg::*;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !bus_rd);

  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    (st == S_OPC) |=> (pc_out == AW'($past(pc_out) + 1'b1)));

  a_r3_zero_page: assert property (@(posedge clk) disable iff (rst)
    (st == S_PLO || st == S_PHI) |-> (bus_addr[AW-1:DW] == '0));

  a_r5_fix_high: assert property (@(posedge clk) disable iff (rst)
    (st == S_FIX) |=> (bus_addr[DW-1:0] == $past(bus_addr[DW-1:0])) &&
      (bus_addr[AW-1:DW] == (AW-DW)'($past(bus_addr[AW-1:DW]) + 1'b1)));

  a_r7_done_after_data: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(st) == S_DATA));

  a_r8_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (st == S_PLO && go) |=> (st == S_PHI));
endmodule

bind izy_load_seq izy_load_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .done     (done),
  .pc_out   (pc_out),
  .st       (state)
);

// File: tb/sim_izy_load_seq.sv
`timescale 1ns/1ps
module sim_izy_load_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [7:0]  idx_y = 8'h00;
  logic [7:0]  rd_data = 8'h00;
  logic [15:0] bus_addr;
  logic        bus_rd;
  logic [7:0]  acc_out;
  logic        done;
  logic [15:0] pc_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_pc = 16'h0200;
  logic [7:0] mem [logic [15:0]];

  always #10 clk = ~clk;

  izy_load_seq u0 (
    .clk(clk), .rst(rst), .go(go), .idx_y(idx_y), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .acc_out(acc_out),
    .done(done), .pc_out(pc_out)
  );

  function automatic logic [7:0] lookup(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5C;
  endfunction

  always @(negedge clk) rd_data <= lookup(bus_addr);

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // vector fields: {operand, ptr_lo, ptr_hi, index, data}
  localparam logic [39:0] VECS [6] = '{
    {8'h42, 8'h80, 8'h10, 8'hF1, 8'h5A},
    {8'h30, 8'h20, 8'h40, 8'h05, 8'hA5},
    {8'hFF, 8'h00, 8'h33, 8'hFF, 8'hC3},
    {8'h50, 8'h01, 8'hFF, 8'hFF, 8'h7E},
    {8'h10, 8'hFF, 8'h20, 8'h00, 8'h11},
    {8'h11, 8'hFF, 8'h20, 8'h01, 8'h22}
  };

  task automatic run_one(input logic [39:0] v, input string fin_tag,
                         input bit poke_mid, input bit chain, input bit started);
    logic [7:0]  zp, lo, hi, y, dat;
    logic [8:0]  s;
    logic [15:0] exp_a [6];
    logic [15:0] got_a [8];
    int exp_n, n;
    bit seen_done;
    {zp, lo, hi, y, dat} = v;
    s = {1'b0, lo} + {1'b0, y};
    exp_a[0] = exp_pc;
    exp_a[1] = exp_pc + 16'd1;
    exp_a[2] = {8'h00, zp};
    exp_a[3] = {8'h00, 8'(zp + 8'd1)};
    if (s[8]) begin
      exp_a[4] = {hi, s[7:0]};
      exp_a[5] = {8'(hi + 8'd1), s[7:0]};
      exp_n = 6;
    end else begin
      exp_a[4] = {hi, s[7:0]};
      exp_a[5] = 16'h0000;
      exp_n = 5;
    end
    mem[exp_pc] = 8'hB1;
    mem[exp_pc + 16'd1] = zp;
    mem[{8'h00, zp}] = lo;
    mem[{8'h00, 8'(zp + 8'd1)}] = hi;
    mem[exp_a[exp_n-1]] = dat;
    idx_y = y;
    if (!started) begin
      @(negedge clk);
      go = 1'b1;
    end
    n = 0;
    seen_done = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (k > 0 || !started) @(negedge clk);
      if (done && !(started && k == 0)) begin
        seen_done = 1'b1;
        break;
      end
      go = 1'b0;
      if (bus_rd && n < 8) begin
        got_a[n] = bus_addr;
        n++;
        if (poke_mid && n == 3) go = 1'b1;
        if (chain && n == exp_n) go = 1'b1;
      end
    end
    go = 1'b0;
    chk("R7", "done seen", 32'(seen_done), 32'd1);
    chk(s[8] ? "R5" : "R4", "strobed cycles", 32'(n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < n; i++) begin
      if (i < 2)       chk("R2", "fetch addr", 32'(got_a[i]), 32'(exp_a[i]));
      else if (i < 4)  chk("R3", "pointer addr", 32'(got_a[i]), 32'(exp_a[i]));
      else if (i == exp_n - 1)
        chk(fin_tag, "final addr", 32'(got_a[i]), 32'(exp_a[i]));
      else             chk("R5", "dummy addr", 32'(got_a[i]), 32'(exp_a[i]));
    end
    chk("R7", "acc value", 32'(acc_out), 32'(dat));
    exp_pc = exp_pc + 16'd2;
    if (!chain) begin
      chk("R2", "pc after load", 32'(pc_out), 32'(exp_pc));
      @(negedge clk);
      chk("R7", "done width", 32'(done), 32'd0);
      chk("R7", "acc held", 32'(acc_out), 32'(dat));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "bus_rd", 32'(bus_rd), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "acc", 32'(acc_out), 32'd0);
    chk("R1", "bus_addr", 32'(bus_addr), 32'd0);
    chk("R1", "pc", 32'(pc_out), 32'h0200);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] ylo;
      logic [8:0] t;
      ylo = VECS[i][15:8];
      t = {1'b0, VECS[i][31:24]} + {1'b0, ylo};
      if (i == 3) run_one(VECS[i], "R6", 1'b0, 1'b0, 1'b0);
      else        run_one(VECS[i], t[8] ? "R5" : "R4", 1'b0, 1'b0, 1'b0);
    end

    // R8: start request in mid-load is ignored
    run_one({8'h60, 8'hC0, 8'h55, 8'h50, 8'h99}, "R5", 1'b1, 1'b0, 1'b0);
    chk("R8", "idle after mid go", 32'(bus_rd), 32'd0);

    // R8: back-to-back loads, done and next fetch in one cycle
    run_one({8'h70, 8'hF0, 8'h21, 8'h20, 8'h3C}, "R5", 1'b0, 1'b1, 1'b0);
    chk("R8", "chain done", 32'(done), 32'd1);
    chk("R8", "chain strobe", 32'(bus_rd), 32'd1);
    chk("R8", "chain fetch addr", 32'(bus_addr), 32'(exp_pc));
    run_one({8'h72, 8'h10, 8'h44, 8'h08, 8'hE7}, "R4", 1'b0, 1'b0, 1'b1);

    // R1: reset in the middle of a load returns to idle
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "strobe after reset", 32'(bus_rd), 32'd0);
    chk("R1", "pc after reset", 32'(pc_out), 32'h0200);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule